// File: doc/BRIEF.md
# Initialization block fetch sequencer

This block loads a controller's operating parameters from a small parameter block in host memory. Software first writes the block's byte address into two 16-bit host registers, low half and high half. It then sets an initialization request bit. The sequencer acts as a bus master. It asks for the bus, reads the block one doubleword at a time and gives the bus back after every second read, so each burst holds at most two reads. It then asks for the bus again and continues until the whole block has been read.

The size of the block depends on a structure-size mode bit. In 32-bit mode the block is seven doublewords long and is read in four bus tenures, the last of which carries a single read. In 16-bit mode the block is six doublewords long and is read in three tenures. As words arrive they are unpacked into the mode word, the two ring base addresses and the two ring lengths. Software can also write the mode word and the ring lengths directly, but a later fetch overwrites them. When the last word has been stored, a done flag is set. An interrupt output follows the done flag whenever interrupts are enabled.

Top module: `initblk_fetch`

## Requirements
- R1: The block base address is `{hi16, lo16[15:2], 2'b00}`, so the two lowest address bits written are ignored. Doubleword k of the block is read at base + 4·k, and every read address has bits [1:0] equal to 0.
- R2: A host write to register select 0 (control) with data bit 0 set starts a fetch when the block is idle. Data bit 1 of the same write is stored as the start flag and appears on `start_o`.
- R3: During each bus tenure at most 2 reads are issued, and a read is only issued while `bm_req` and `bm_gnt` are both high. After the second read of a tenure has been acknowledged, `bm_req` is deasserted for at least one cycle.
- R4: With the size bit set (register select 3, data bit 0 = 1), exactly 7 doublewords are read in exactly 4 rising edges of `bm_req`. The final tenure issues one read.
- R5: With the size bit clear, exactly 6 doublewords are read in exactly 3 rising edges of `bm_req`.
- R6: 32-bit layout. Word 0 gives `mode_o`=[15:0] and `rx_len_o`=[31:16]. Word 1 [15:0] gives `tx_len_o`. Word 5 gives `rx_base_o` and word 6 gives `tx_base_o`, each with bits [3:0] forced to 0. Words 2 to 4 are discarded.
- R7: 16-bit layout. Word 0 [15:0] gives `mode_o`. Word 4 gives `rx_base_o` = `{8'h00, w[23:3], 3'b000}` and `rx_len_o` = 1 << w[31:29]. Word 5 gives the transmit pair in the same way. Words 1 to 3 are discarded.
- R8: `idon_o` rises after the last word has been stored and stays high until the host writes control bit 3 = 1 or a new fetch starts. `irq_o` is high exactly when `idon_o` is high and the interrupt-enable bit (control bit 2) is set.
- R9: Direct writes to select 4 (mode), 5 (receive length) and 6 (transmit length) update the outputs immediately. A fetch started afterwards overwrites them with the block's values.
- R10: A control write with bit 0 set while a fetch is in progress is ignored. No second fetch follows the current one.
- R11: After reset `bm_req`, `bm_rd`, `busy_o`, `idon_o`, `irq_o`, `start_o` and all parameter outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 3 | Host register select |
| hw_data | input | 16 | Host write data |
| bm_req | output | 1 | Bus request |
| bm_gnt | input | 1 | Bus grant |
| bm_rd | output | 1 | Read strobe, one cycle per doubleword |
| bm_addr | output | 32 | Read byte address |
| bm_ack | input | 1 | Read data valid |
| bm_rdata | input | 32 | Read data |
| busy_o | output | 1 | Fetch in progress |
| idon_o | output | 1 | Initialization done flag |
| irq_o | output | 1 | Interrupt request |
| start_o | output | 1 | Stored start flag |
| mode_o | output | 16 | Mode word |
| rx_base_o | output | 32 | Receive ring base |
| tx_base_o | output | 32 | Transmit ring base |
| rx_len_o | output | 16 | Receive ring length |
| tx_len_o | output | 16 | Transmit ring length |

## Verification
The hardest case to reach from the ports is a second initialization request that arrives in the middle of a fetch. The request has to land after bus traffic has begun and before the last word has arrived. To get there, the bench counts acknowledged reads and issues the repeated control write right after the third acknowledge. It then counts bus-request rising edges and reads through the end of the fetch and for a long quiet period afterwards. The clobbering of direct writes is reached by the same kind of ordering: direct writes are made first, the outputs are checked, and then a fetch is started and the outputs are checked again.

// File: rtl/initblk_pkg.sv
package initblk_pkg;
  localparam int unsigned DW_W      = 32;
  localparam int unsigned HW_W      = 16;
  localparam int unsigned IDX_W     = 3;
  localparam int unsigned BURST_LEN = 2;
  localparam int unsigned WORDS32   = 7;
  localparam int unsigned WORDS16   = 6;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_REQ, SQ_RD, SQ_WAIT, SQ_GAP, SQ_FIN
  } seq_state_t;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_ALO   = 3'd1;
  localparam logic [2:0] SEL_AHI   = 3'd2;
  localparam logic [2:0] SEL_SIZE  = 3'd3;
  localparam logic [2:0] SEL_MODE  = 3'd4;
  localparam logic [2:0] SEL_RXLEN = 3'd5;
  localparam logic [2:0] SEL_TXLEN = 3'd6;

  function automatic logic [IDX_W-1:0] last_index(input logic m32);
    return m32 ? IDX_W'(WORDS32 - 1) : IDX_W'(WORDS16 - 1);
  endfunction

  function automatic logic [DW_W-1:0] block_base(input logic [HW_W-1:0] hi,
                                                 input logic [HW_W-1:0] lo);
    return {hi, lo[HW_W-1:2], 2'b00};
  endfunction

  function automatic logic [DW_W-1:0] word_addr(input logic [DW_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + {{(DW_W-IDX_W-2){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [HW_W-1:0] pow2_len(input logic [2:0] code);
    return HW_W'(1) << code;
  endfunction

  function automatic logic [DW_W-1:0] base16(input logic [DW_W-1:0] w);
    return {8'h00, w[23:3], 3'b000};
  endfunction
endpackage

// File: rtl/initblk_regs.sv
module initblk_regs
  import initblk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_en,
  input  logic [2:0]      hw_sel,
  input  logic [HW_W-1:0] hw_data,
  input  logic            busy,
  input  logic            fin,
  output logic [HW_W-1:0] addr_lo,
  output logic [HW_W-1:0] addr_hi,
  output logic            size32,
  output logic            iena,
  output logic            start,
  output logic            idon,
  output logic            init_go
);
  logic ctrl_wr;
  assign ctrl_wr = hw_en && (hw_sel == SEL_CTRL);
  assign init_go = ctrl_wr && hw_data[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
      size32  <= 1'b0;
      iena    <= 1'b0;
      start   <= 1'b0;
      idon    <= 1'b0;
    end else begin
      if (hw_en && hw_sel == SEL_ALO)  addr_lo <= hw_data;
      if (hw_en && hw_sel == SEL_AHI)  addr_hi <= hw_data;
      if (hw_en && hw_sel == SEL_SIZE) size32  <= hw_data[0];
      if (ctrl_wr) begin
        iena  <= hw_data[2];
        start <= hw_data[1];
      end
      if (fin)                         idon <= 1'b1;
      else if (init_go)                idon <= 1'b0;
      else if (ctrl_wr && hw_data[3])  idon <= 1'b0;
    end
  end
endmodule

// File: rtl/initblk_seq.sv
module initblk_seq
  import initblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_go,
  input  logic [HW_W-1:0]  addr_lo,
  input  logic [HW_W-1:0]  addr_hi,
  input  logic             size32,
  output logic             bm_req,
  input  logic             bm_gnt,
  output logic             bm_rd,
  output logic [DW_W-1:0]  bm_addr,
  input  logic             bm_ack,
  output logic             busy,
  output logic             fin,
  output logic             word_ok,
  output logic [IDX_W-1:0] word_idx,
  output logic             fetch32
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

  seq_state_t           st;
  logic [DW_W-1:0]      base_q;
  logic [IDX_W-1:0]     idx_q;
  logic [BEAT_W-1:0]    beat_q;
  logic                 is_last;

  assign is_last  = (idx_q == last_index(fetch32));
  assign bm_req   = (st == SQ_REQ) || (st == SQ_RD) || (st == SQ_WAIT);
  assign bm_rd    = (st == SQ_RD);
  assign bm_addr  = word_addr(base_q, idx_q);
  assign busy     = (st != SQ_IDLE);
  assign fin      = (st == SQ_FIN);
  assign word_ok  = (st == SQ_WAIT) && bm_ack;
  assign word_idx = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      beat_q  <= '0;
      fetch32 <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (init_go) begin
          base_q  <= block_base(addr_hi, addr_lo);
          fetch32 <= size32;
          idx_q   <= '0;
          beat_q  <= '0;
          st      <= SQ_REQ;
        end
        SQ_REQ:  if (bm_gnt) st <= SQ_RD;
        SQ_RD:   st <= SQ_WAIT;
        SQ_WAIT: if (bm_ack) begin
          if (is_last) begin
            st <= SQ_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (beat_q == BEAT_LAST) begin
              beat_q <= '0;
              st     <= SQ_GAP;
            end else begin
              beat_q <= beat_q + 1'b1;
              st     <= SQ_RD;
            end
          end
        end
        SQ_GAP:  st <= SQ_REQ;
        SQ_FIN:  st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/initblk_unpack.sv
module initblk_unpack
  import initblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_ok,
  input  logic [IDX_W-1:0] word_idx,
  input  logic             fetch32,
  input  logic [DW_W-1:0]  rdata,
  input  logic             hw_en,
  input  logic [2:0]       hw_sel,
  input  logic [HW_W-1:0]  hw_data,
  output logic [HW_W-1:0]  mode,
  output logic [DW_W-1:0]  rx_base,
  output logic [DW_W-1:0]  tx_base,
  output logic [HW_W-1:0]  rx_len,
  output logic [HW_W-1:0]  tx_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= '0;
      rx_base <= '0;
      tx_base <= '0;
      rx_len  <= '0;
      tx_len  <= '0;
    end else if (word_ok) begin
      if (fetch32) begin
        case (word_idx)
          3'd0: begin
            mode   <= rdata[15:0];
            rx_len <= rdata[31:16];
          end
          3'd1: tx_len  <= rdata[15:0];
          3'd5: rx_base <= {rdata[31:4], 4'h0};
          3'd6: tx_base <= {rdata[31:4], 4'h0};
          default: ;
        endcase
      end else begin
        case (word_idx)
          3'd0: mode <= rdata[15:0];
          3'd4: begin
            rx_base <= base16(rdata);
            rx_len  <= pow2_len(rdata[31:29]);
          end
          3'd5: begin
            tx_base <= base16(rdata);
            tx_len  <= pow2_len(rdata[31:29]);
          end
          default: ;
        endcase
      end
    end else if (hw_en) begin
      case (hw_sel)
        SEL_MODE:  mode   <= hw_data;
        SEL_RXLEN: rx_len <= hw_data;
        SEL_TXLEN: tx_len <= hw_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/initblk_fetch.sv
module initblk_fetch
  import initblk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_en,
  input  logic [2:0]  hw_sel,
  input  logic [15:0] hw_data,
  output logic        bm_req,
  input  logic        bm_gnt,
  output logic        bm_rd,
  output logic [31:0] bm_addr,
  input  logic        bm_ack,
  input  logic [31:0] bm_rdata,
  output logic        busy_o,
  output logic        idon_o,
  output logic        irq_o,
  output logic        start_o,
  output logic [15:0] mode_o,
  output logic [31:0] rx_base_o,
  output logic [31:0] tx_base_o,
  output logic [15:0] rx_len_o,
  output logic [15:0] tx_len_o
);
  logic [HW_W-1:0]  addr_lo, addr_hi;
  logic             size32, iena, init_go, fin, word_ok, fetch32;
  logic [IDX_W-1:0] word_idx;

  initblk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .busy(busy_o), .fin(fin), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .size32(size32), .iena(iena), .start(start_o), .idon(idon_o), .init_go(init_go)
  );

  initblk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init_go(init_go), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .size32(size32), .bm_req(bm_req), .bm_gnt(bm_gnt), .bm_rd(bm_rd),
    .bm_addr(bm_addr), .bm_ack(bm_ack), .busy(busy_o), .fin(fin),
    .word_ok(word_ok), .word_idx(word_idx), .fetch32(fetch32)
  );

  initblk_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .word_idx(word_idx),
    .fetch32(fetch32), .rdata(bm_rdata), .hw_en(hw_en), .hw_sel(hw_sel),
    .hw_data(hw_data), .mode(mode_o), .rx_base(rx_base_o), .tx_base(tx_base_o),
    .rx_len(rx_len_o), .tx_len(tx_len_o)
  );

  assign irq_o = idon_o && iena;
endmodule

// File: rtl/initblk_chk.sv
module initblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bm_req,
  input logic        bm_gnt,
  input logic        bm_rd,
  input logic [31:0] bm_addr,
  input logic        busy_o,
  input logic        idon_o,
  input logic        fin,
  input logic        init_go
);
  logic [2:0] rd_in_tenure;
  always_ff @(posedge clk) begin
    if (!rst_n || !bm_req) rd_in_tenure <= '0;
    else if (bm_rd)        rd_in_tenure <= rd_in_tenure + 1'b1;
  end

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd |-> (bm_addr[1:0] == 2'b00)); // R1
  AST_RD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd |-> (bm_req && bm_gnt)); // R3
  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd |-> (rd_in_tenure < 3'd2)); // R3
  AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> idon_o); // R8
  AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(init_go)); // R10
endmodule

bind initblk_fetch initblk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bm_req(bm_req), .bm_gnt(bm_gnt), .bm_rd(bm_rd),
  .bm_addr(bm_addr), .busy_o(busy_o), .idon_o(idon_o), .fin(fin), .init_go(init_go)
);

// File: tb/initblk_fetch_tb.sv
`timescale 1ns/1ps
module initblk_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b0;
  logic [2:0]  hw_sel = '0;
  logic [15:0] hw_data = '0;
  logic        bm_req, bm_rd, bm_ack;
  logic        bm_gnt;
  logic [31:0] bm_addr, bm_rdata;
  logic        busy_o, idon_o, irq_o, start_o;
  logic [15:0] mode_o, rx_len_o, tx_len_o;
  logic [31:0] rx_base_o, tx_base_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  initblk_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .bm_req(bm_req), .bm_gnt(bm_gnt), .bm_rd(bm_rd), .bm_addr(bm_addr),
    .bm_ack(bm_ack), .bm_rdata(bm_rdata), .busy_o(busy_o), .idon_o(idon_o),
    .irq_o(irq_o), .start_o(start_o), .mode_o(mode_o), .rx_base_o(rx_base_o),
    .tx_base_o(tx_base_o), .rx_len_o(rx_len_o), .tx_len_o(tx_len_o)
  );

  // memory and arbiter model
  logic [31:0] mem [0:7];
  logic [31:0] mem_base = '0;
  logic        g1 = 1'b0, g2 = 1'b0;
  logic        ack_q = 1'b0;
  logic [31:0] rdata_q = '0;
  logic        bad_addr = 1'b0;
  assign bm_gnt   = bm_req && g1 && g2;
  assign bm_ack   = ack_q;
  assign bm_rdata = rdata_q;

  int req_rises = 0, reads = 0, acks = 0, max_tenure = 0, cur_tenure = 0;
  logic req_q = 1'b0;

  always @(posedge clk) begin
    g1 <= bm_req;
    g2 <= g1 && bm_req;
    ack_q <= bm_rd;
    if (bm_rd) begin
      if (bm_addr < mem_base || bm_addr[1:0] != 2'b00 || ((bm_addr - mem_base) >> 2) > 7)
        bad_addr <= 1'b1;
      rdata_q <= mem[3'((bm_addr - mem_base) >> 2)];
    end
    req_q <= bm_req;
    if (bm_req && !req_q) req_rises <= req_rises + 1;
    if (bm_ack) acks <= acks + 1;
    if (!bm_req) cur_tenure <= 0;
    else if (bm_rd) begin
      cur_tenure <= cur_tenure + 1;
      reads <= reads + 1;
      if (cur_tenure + 1 > max_tenure) max_tenure <= cur_tenure + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_sel = sel; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic clear_counts;
    @(negedge clk);
    req_rises = 0; reads = 0; acks = 0; max_tenure = 0; bad_addr = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    while (!idon_o && n < 500) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 req",   {31'd0, bm_req},  32'd0);
    check("R11 rd",    {31'd0, bm_rd},   32'd0);
    check("R11 busy",  {31'd0, busy_o},  32'd0);
    check("R11 idon",  {31'd0, idon_o},  32'd0);
    check("R11 irq",   {31'd0, irq_o},   32'd0);
    check("R11 start", {31'd0, start_o}, 32'd0);
    check("R11 params", {mode_o, rx_len_o} | tx_len_o | rx_base_o | tx_base_o, 32'd0);
  endtask

  task automatic t_fetch32;
    mem[0] = 32'h0040_8A5C; mem[1] = 32'h1234_0033; mem[2] = 32'hDEAD_BEEF;
    mem[3] = 32'hCAFE_F00D; mem[4] = 32'h0BAD_CAFE; mem[5] = 32'h0012_345F;
    mem[6] = 32'h0067_89AB; mem[7] = 32'hFFFF_FFFF;
    mem_base = 32'h00AB_1230;
    wr(3'd1, 16'h1233);           // low two bits ignored (R1)
    wr(3'd2, 16'h00AB);
    wr(3'd3, 16'h0001);
    clear_counts();
    wr(3'd0, 16'h0007);           // init + start + iena
    check("R2 busy after init", {31'd0, busy_o}, 32'd1);
    check("R2 start flag", {31'd0, start_o}, 32'd1);
    wait_done();
    check("R1 addresses", {31'd0, bad_addr}, 32'd0);
    check("R4 reads", reads, 7);
    check("R4 arbitrations", req_rises, 4);
    check("R3 max reads per tenure", max_tenure, 2);
    check("R6 mode", mode_o, 32'h8A5C);
    check("R6 rx_len", rx_len_o, 32'h0040);
    check("R6 tx_len", tx_len_o, 32'h0033);
    check("R6 rx_base", rx_base_o, 32'h0012_3450);
    check("R6 tx_base", tx_base_o, 32'h0067_89A0);
    check("R8 idon", {31'd0, idon_o}, 32'd1);
    check("R8 irq", {31'd0, irq_o}, 32'd1);
    wr(3'd0, 16'h0002);           // iena off, start kept
    check("R8 irq masked", {31'd0, irq_o}, 32'd0);
    check("R8 idon held", {31'd0, idon_o}, 32'd1);
    wr(3'd0, 16'h000C);           // w1c idon, iena on
    check("R8 idon cleared", {31'd0, idon_o}, 32'd0);
    check("R8 irq after clear", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_fetch16;
    mem[0] = 32'h5555_1E0F; mem[1] = 32'h1111_1111; mem[2] = 32'h2222_2222;
    mem[3] = 32'h3333_3333; mem[4] = 32'hE0AB_CDEF; mem[5] = 32'h4012_3456;
    mem[6] = 32'h7777_7777; mem[7] = 32'h8888_8888;
    mem_base = 32'h0000_4000;
    wr(3'd1, 16'h4000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    clear_counts();
    wr(3'd0, 16'h0001);
    wait_done();
    check("R1 addresses 16", {31'd0, bad_addr}, 32'd0);
    check("R5 reads", reads, 6);
    check("R5 arbitrations", req_rises, 3);
    check("R3 max reads per tenure 16", max_tenure, 2);
    check("R7 mode", mode_o, 32'h1E0F);
    check("R7 rx_base", rx_base_o, 32'h00AB_CDE8);
    check("R7 rx_len", rx_len_o, 32'd128);
    check("R7 tx_base", tx_base_o, 32'h0012_3450);
    check("R7 tx_len", tx_len_o, 32'd4);
    check("R2 start cleared", {31'd0, start_o}, 32'd0);
    check("R8 irq disabled", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_clobber;
    wr(3'd4, 16'hA1A1);
    wr(3'd5, 16'h0999);
    wr(3'd6, 16'h0777);
    check("R9 direct mode", mode_o, 32'hA1A1);
    check("R9 direct rx_len", rx_len_o, 32'h0999);
    check("R9 direct tx_len", tx_len_o, 32'h0777);
    wr(3'd0, 16'h0009);           // clear idon and start a new fetch
    wait_done();
    check("R9 mode overwritten", mode_o, 32'h1E0F);
    check("R9 rx_len overwritten", rx_len_o, 32'd128);
    check("R9 tx_len overwritten", tx_len_o, 32'd4);
  endtask

  task automatic t_busy_init;
    int n = 0;
    clear_counts();
    wr(3'd0, 16'h0001);
    while (acks < 3 && n < 200) begin
      @(negedge clk);
      n++;
    end
    wr(3'd0, 16'h0001);           // request while busy: ignored (R10)
    wait_done();
    repeat (60) @(negedge clk);
    check("R10 reads", reads, 6);
    check("R10 arbitrations", req_rises, 3);
    check("R10 idle after", {31'd0, busy_o}, 32'd0);
    check("R10 idon", {31'd0, idon_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fetch32();
    t_fetch16();
    t_clobber();
    t_busy_init();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule